// File: doc/BRIEF.md
# Clock-Control Register Target on a Two-Wire Bus

This block is a write-only target on a two-wire serial bus with open-drain clock and data lines. A host starts a transfer with a START condition and sends an address byte, then a run of data bytes. The block oversamples both lines with its own system clock. When the address names this device in write direction, it acknowledges each byte. Data bytes at positions 4, 5 and 6 of the transfer load three 8-bit control registers, which drive the clock tree of a system clock generator.

The first enable register gates the two 48 MHz outputs, the two graphics-port clocks, the first 14.318 MHz reference and the three differential processor clock pairs. The second gates the second reference and the seven stoppable PCI clocks. The mode register holds the spread-spectrum enable, a 3-bit frequency/test code, a select between pin straps and register settings, and the SDRAM output enable. Data bytes at positions 0 to 3 and any byte after position 6 are acknowledged and thrown away.

Top module: `clkctl_smb_slave`

## Requirements
- R1: Reset loads `en_clk_a` = 0xFF, `en_clk_b` = 0xFF and `gen_mode` = 0x7D: every enable bit set, spread (bit 7) off, code bits 6:4 = 111, register-select (bit 1) 0 so pin straps are used, SDRAM enable (bit 0) 1.
- R2: An address byte of 0xD2 acknowledges. That is device address 1101001 in bits 7:1 with R/W bit 0 = 0 (write). The block pulls SDA low for the whole ninth SCL clock, and starts pulling only while SCL is low.
- R3: Any other address byte, including 0xD3 (read direction), gets no acknowledge. Every byte after it is also left unacknowledged and has no effect on any register, until the next START.
- R4: Every byte is taken in most significant bit first. The first data bit clocked in lands in bit 7.
- R5: Data bytes at positions 0, 1, 2 and 3 after the address are acknowledged and change no register.
- R6: The data byte at position 4 loads `en_clk_a`, position 5 loads `en_clk_b`, and position 6 loads `gen_mode`, with 1 = output active in both enable registers. `en_clk_a` bits: 7 first reference, 6 selectable 48/24 MHz output, 5 dedicated 48 MHz output, 4:3 graphics clocks 1:0, 2:0 processor pairs 2:0. `en_clk_b` bits: 7 second reference, 6:0 PCI clocks 6:0.
- R7: Data bytes at position 7 and beyond are acknowledged and change no register.
- R8: A register changes only after the eighth bit of its byte has been clocked in. A transfer ended by STOP part-way through a byte leaves that register unchanged.
- R9: A START (SDA falls while SCL high) or a STOP (SDA rises while SCL high) resets the byte position. After a repeated START, the next data byte is position 0 again.
- R10: At most one control register changes in any system clock cycle, and none changes without a completed byte write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Drives the data line low when 1 (open drain) |
| en_clk_a | output | 8 | Enables for references, USB, graphics and processor clocks |
| en_clk_b | output | 8 | Enables for second reference and PCI clocks |
| gen_mode | output | 8 | Spread, frequency code, source select and SDRAM enable |

## Verification
Two events can land in the same stretch of bus activity. The release of the acknowledge after the ninth clock can meet a START that the host begins on the very next low phase of SCL. Also, the byte-position counter reset can meet a byte completion. The bench issues a repeated START right after an acknowledged data byte, partway through the register window. It then checks that the following data byte is taken as position 0, so the register loaded is the one given by the new transfer's own byte positions. Random transfers of varied length and address mix the two against a model of the byte positions.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          ADDR_W    = 7;
    localparam logic [6:0]  DEV_ADDR  = 7'b1101001;
    localparam int          FIRST_REG = 4;
    localparam int          NUM_REGS  = 3;
    localparam int          POS_MAX   = FIRST_REG + NUM_REGS;
    localparam int          POS_W     = $clog2(POS_MAX + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_ACKW,
        PH_ACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              stb;
        logic [POS_W-1:0]  pos;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(logic [BYTE_W-1:0] b);
        return (b[BYTE_W-1:1] == DEV_ADDR) && !b[0];
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFF;
            default: return 8'h7D;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_bus_sampler.sv
module clkctl_bus_sampler
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic                   scl_prev;
    logic                   sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q    <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_q[SYNC_STAGES-1];
            sda_prev <= sda_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_q[SYNC_STAGES-1];
        ev.sda      = sda_q[SYNC_STAGES-1];
        ev.scl_rise = ev.scl & ~scl_prev;
        ev.scl_fall = ~ev.scl & scl_prev;
        ev.start    = ev.scl & scl_prev & sda_prev & ~ev.sda;
        ev.stop     = ev.scl & scl_prev & ~sda_prev & ev.sda;
    end

endmodule

// File: rtl/clkctl_frame_engine.sv
module clkctl_frame_engine
    import clkctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output wr_req_t wr,
    output logic    sda_pull
);

    phase_e            phase;
    logic [BYTE_W-1:0] shreg;
    logic [2:0]        bitcnt;
    logic [POS_W-1:0]  pos;
    logic [BYTE_W-1:0] next_byte;

    assign next_byte = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            pos    <= '0;
            wr     <= '0;
        end else begin
            wr.stb <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
                pos    <= '0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                pos    <= '0;
            end else begin
                case (phase)
                    PH_ADDR, PH_DATA: begin
                        if (ev.scl_rise) begin
                            shreg  <= next_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                if (phase == PH_ADDR) begin
                                    phase <= addr_hit(next_byte) ? PH_ACKW : PH_SKIP;
                                end else begin
                                    phase   <= PH_ACKW;
                                    wr.stb  <= 1'b1;
                                    wr.pos  <= pos;
                                    wr.data <= next_byte;
                                    if (pos != POS_W'(POS_MAX))
                                        pos <= pos + 1'b1;
                                end
                            end
                        end
                    end
                    PH_ACKW: if (ev.scl_fall) phase <= PH_ACK;
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            phase  <= PH_DATA;
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (phase == PH_ACK);

endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank
    import clkctl_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int BASE   = FIRST_REG
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       wr,
    output logic [N_REGS-1:0][BYTE_W-1:0] regs
);

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam logic [POS_W-1:0] SLOT = POS_W'(BASE + g);
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= reg_default(g);
            else if (wr.stb && wr.pos == SLOT)
                regs[g] <= wr.data;
        end
    end

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
    import clkctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    output logic [7:0]  en_clk_a,
    output logic [7:0]  en_clk_b,
    output logic [7:0]  gen_mode
);

    bus_ev_t                        ev;
    wr_req_t                        wr;
    logic [NUM_REGS-1:0][BYTE_W-1:0] clk_regs;

    clkctl_bus_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    clkctl_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .wr       (wr),
        .sda_pull (sda_pull)
    );

    clkctl_reg_bank #(.N_REGS(NUM_REGS), .BASE(FIRST_REG)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (clk_regs)
    );

    assign en_clk_a = clk_regs[0];
    assign en_clk_b = clk_regs[1];
    assign gen_mode = clk_regs[2];

endmodule

// File: rtl/clkctl_smb_checker.sv
module clkctl_smb_checker
    import clkctl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input bus_ev_t    ev,
    input wr_req_t    wr,
    input logic       sda_pull,
    input logic [7:0] en_clk_a,
    input logic [7:0] en_clk_b,
    input logic [7:0] gen_mode
);

    assert_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (en_clk_a == 8'hFF && en_clk_b == 8'hFF && gen_mode == 8'h7D));

    assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

    assert_write_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        wr.stb |-> $past(ev.scl_rise));

    assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_pull);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr.stb |=> $stable({en_clk_a, en_clk_b, gen_mode}));

    assert_one_change_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({en_clk_a != $past(en_clk_a),
                    en_clk_b != $past(en_clk_b),
                    gen_mode != $past(gen_mode)}) <= 1);

endmodule

bind clkctl_smb_slave clkctl_smb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .wr       (wr),
    .sda_pull (sda_pull),
    .en_clk_a (en_clk_a),
    .en_clk_b (en_clk_b),
    .gen_mode (gen_mode)
);

// File: tb/clkctl_smb_slave_bench.sv
module clkctl_smb_slave_bench;

    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_pull;
    logic sda_w;
    logic [7:0] en_clk_a, en_clk_b, gen_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_r [3];
    logic [7:0] buf_b [10];

    always #10 clk = ~clk;

    assign sda_w = sda_h & ~sda_pull;

    clkctl_smb_slave u_clkctl_smb_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_h),
        .sda_in   (sda_w),
        .sda_pull (sda_pull),
        .en_clk_a (en_clk_a),
        .en_clk_b (en_clk_b),
        .gen_mode (gen_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(en_clk_a == exp_r[0], req, 32'(en_clk_a), 32'(exp_r[0]));
        chk(en_clk_b == exp_r[1], req, 32'(en_clk_b), 32'(exp_r[1]));
        chk(gen_mode == exp_r[2], req, 32'(gen_mode), 32'(exp_r[2]));
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; tick(Q);
        scl_h = 1'b1; tick(2 * Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        acked = ~sda_w; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    // model: byte positions 4..6 map to the three registers (R6), others dropped (R5, R7)
    function automatic void model_apply(input int n);
        for (int i = 0; i < n; i++)
            if (i >= 4 && i <= 6) exp_r[i-4] = buf_b[i];
    endfunction

    // sends address and n bytes from buf_b, no START/STOP
    task automatic body(input logic [7:0] abyte, input int n, input string req);
        logic a;
        logic hit;
        hit = (abyte == 8'hD2);
        send_byte(abyte, a);
        chk(a == hit, hit ? "R2" : "R3", 32'(a), 32'(hit));
        for (int i = 0; i < n; i++) begin
            send_byte(buf_b[i], a);
            chk(a == hit, req, 32'(a), 32'(hit));
        end
        if (hit) model_apply(n);
    endtask

    task automatic xfer(input logic [7:0] abyte, input int n, input string req);
        bus_start();
        body(abyte, n, req);
        bus_stop();
        tick(4);
    endtask

    initial begin
        int unused_seed;
        logic a;
        unused_seed = $urandom(32'd2024);
        tick(5);
        rst = 1'b0;
        tick(3);

        exp_r[0] = 8'hFF; exp_r[1] = 8'hFF; exp_r[2] = 8'h7D;
        check_regs("R1");
        chk(sda_pull == 1'b0, "R1", 32'(sda_pull), 0);

        // R6: full register window
        buf_b[0] = 8'h11; buf_b[1] = 8'h22; buf_b[2] = 8'h33; buf_b[3] = 8'h44;
        buf_b[4] = 8'h5A; buf_b[5] = 8'hC3; buf_b[6] = 8'hF2;
        xfer(8'hD2, 7, "R5");
        check_regs("R6");

        // R5: only the discarded positions
        buf_b[0] = 8'h00; buf_b[1] = 8'h00; buf_b[2] = 8'h00; buf_b[3] = 8'h00;
        xfer(8'hD2, 4, "R5");
        check_regs("R5");

        // R4: MSB first, 0x80 must not appear as 0x01
        buf_b[4] = 8'h01; buf_b[5] = 8'h80;
        xfer(8'hD2, 6, "R4");
        chk(en_clk_b == 8'h80, "R4", 32'(en_clk_b), 32'h80);
        check_regs("R4");

        // R7: bytes past position 6 ignored
        for (int i = 0; i < 10; i++) buf_b[i] = 8'(8'hA0 + i);
        xfer(8'hD2, 10, "R7");
        check_regs("R7");

        // R3: wrong address and read direction
        for (int i = 0; i < 10; i++) buf_b[i] = 8'h0F;
        xfer(8'hA4, 7, "R3");
        check_regs("R3");
        xfer(8'hD3, 7, "R3");
        check_regs("R3");

        // R8: STOP in the middle of byte 4
        bus_start();
        buf_b[0] = 8'h99; buf_b[1] = 8'h99; buf_b[2] = 8'h99; buf_b[3] = 8'h99;
        body(8'hD2, 4, "R8");
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        scl_h = 1'b0;
        bus_stop();
        tick(4);
        check_regs("R8");

        // R9: repeated START right after an acknowledged byte
        bus_start();
        for (int i = 0; i < 5; i++) buf_b[i] = 8'h66;
        body(8'hD2, 5, "R9");
        bus_start();
        for (int i = 0; i < 6; i++) buf_b[i] = 8'(8'h30 + i);
        body(8'hD2, 6, "R9");
        bus_stop();
        tick(4);
        chk(en_clk_a == 8'h34, "R9", 32'(en_clk_a), 32'h34);
        check_regs("R9");

        // random transfers
        for (int t = 0; t < 24; t++) begin
            int n;
            logic [7:0] ab;
            n  = int'($urandom_range(0, 9));
            ab = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'hD2;
            for (int i = 0; i < 10; i++) buf_b[i] = 8'($urandom);
            xfer(ab, n, "R6");
            check_regs("R10");
        end

        a = 1'b0;
        chk(sda_pull == a, "R2", 32'(sda_pull), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule